// File: doc/BRIEF.md
# Flag Offset Register Loader

This block sets up the two threshold offsets of a FIFO's almost-empty and almost-full flags. The almost-empty offset is called X and the almost-full offset is called Y. Each is 11 bits wide by default. The loading method is taken from three select pins while reset is held. There are three methods:

- a fixed preset value, loaded into both offsets;
- two ordinary writes over the 36-bit port A data bus;
- a serial bit stream clocked by the port A clock.

After reset, two of the three select pins change role: one becomes the serial enable and the other the serial data.

The block drives both offsets and a `progDone` signal. The FIFO uses `progDone` to hold off normal data writes until the offsets are valid. The flag comparators read X and Y directly. The FIFO storage and the comparisons themselves are outside this block.

Top module: `offset_loader`

## Requirements
- R1: The method code `{selHi, serEnN, serData}` is captured on every clock edge while `rstN` is low. Once `rstN` is high, these pins have no effect on the chosen method.
- R2: A preset code loads X and Y with the same value, and `progDone` is high from the first reset edge onward. The code values are 000=8, 001=16, 010=64, 011=256, 100=1024, and 111 is treated as 000.
- R3: With code 101 (serial) or 110 (parallel) held in reset, the first reset edge clears X and Y to 0 and drives `progDone` low.
- R4: In serial mode, each rising edge with `serEnN` low shifts `serData` into a 22-bit chain `{Y,X}`. An edge with `serEnN` high leaves the chain unchanged.
- R5: Serial programming needs exactly 22 bits. The first bit becomes Y bit 10 and the last becomes X bit 0. `progDone` rises on the edge that takes the 22nd bit and not before.
- R6: In parallel mode (110), the first edge with `wrEn` high loads Y from `busA[10:0]`. The second such edge loads X and raises `progDone`. Bus bits 35:11 are ignored.
- R7: Once `progDone` is high, further serial bits and port A writes leave X and Y unchanged. `progDone` stays high until the next reset.
- R8: In serial mode, port A writes have no effect. In parallel mode, the serial enable has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset; the method code is sampled while it is low |
| selHi | input | 1 | Method select bit 2 |
| serEnN | input | 1 | Method select bit 1 in reset; active-low serial enable afterwards |
| serData | input | 1 | Method select bit 0 in reset; serial data bit afterwards |
| wrEn | input | 1 | Port A write enable |
| busA | input | 36 | Port A data bus |
| offX | output | 11 | Almost-empty offset X |
| offY | output | 11 | Almost-full offset Y |
| progDone | output | 1 | High once the offsets are programmed |

## Verification
All results come from registers one clock edge after their stimulus:

- the reset-time load and the preset values;
- each serial shift;
- each parallel write;
- the rise of `progDone`.

The bench drives inputs on the falling edge and samples on the next falling edge, so every check sees exactly one rising edge after its stimulus. After every serial bit it compares the whole `{Y,X}` chain against a bench model. It checks `progDone` just before and just after the 22nd bit and the second parallel write. The "ignored" cases are checked by reading X and Y on the falling edge that follows the ignored cycle.

// File: rtl/offload_pkg.sv
package offload_pkg;

  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2
  } loadMode_e;

  typedef struct packed {
    logic clearAll;
    logic loadPreset;
    logic shiftIn;
    logic loadY;
    logic loadX;
  } ofsStrobe_t;

  localparam logic [2:0] CODE_SERIAL   = 3'b101;
  localparam logic [2:0] CODE_PARALLEL = 3'b110;

  function automatic loadMode_e decodeMode(input logic [2:0] code);
    if (code == CODE_SERIAL) return MODE_SERIAL;
    if (code == CODE_PARALLEL) return MODE_PARALLEL;
    return MODE_PRESET;
  endfunction

  function automatic int unsigned presetValue(input logic [2:0] code);
    case (code)
      3'b001:  return 16;
      3'b010:  return 64;
      3'b011:  return 256;
      3'b100:  return 1024;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/ofl_ctrl.sv
module ofl_ctrl
  import offload_pkg::*;
#(
  parameter int CHAIN_LEN = 22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] selCode,
  input  logic       serEnN,
  input  logic       wrEn,
  output ofsStrobe_t strb,
  output logic       progDone
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 1);

  loadMode_e        modeQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;
  logic             selIsPreset;
  logic             serStep;
  logic             parStep;

  assign selIsPreset = (decodeMode(selCode) == MODE_PRESET);
  assign serStep = rstN && !doneQ && (modeQ == MODE_SERIAL) && !serEnN;
  assign parStep = rstN && !doneQ && (modeQ == MODE_PARALLEL) && wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= decodeMode(selCode);
      cntQ  <= '0;
      doneQ <= selIsPreset;
    end else if (serStep) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == CNT_W'(CHAIN_LEN - 1)) doneQ <= 1'b1;
    end else if (parStep) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == CNT_W'(1)) doneQ <= 1'b1;
    end
  end

  always_comb begin
    strb.clearAll   = !rstN && !selIsPreset;
    strb.loadPreset = !rstN && selIsPreset;
    strb.shiftIn    = serStep;
    strb.loadY      = parStep && (cntQ == CNT_W'(0));
    strb.loadX      = parStep && (cntQ == CNT_W'(1));
  end

  assign progDone = doneQ;

  // R1: the method cannot change outside reset
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(modeQ));

  // R7: done is sticky until reset
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ);

  // R5: serial completion coincides with the full bit count
  a_r5_done_at_count: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SERIAL) |-> (doneQ == (cntQ == CNT_W'(CHAIN_LEN))));

  // R6: parallel done only after two writes
  a_r6_par_count: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_PARALLEL) |-> (doneQ == (cntQ == CNT_W'(2))));

  // R8: at most one datapath action per edge
  a_r8_one_action: assert property (@(posedge clk)
    $onehot0({strb.clearAll, strb.loadPreset, strb.shiftIn, strb.loadY, strb.loadX}));

endmodule

// File: rtl/ofl_data.sv
module ofl_data
  import offload_pkg::*;
#(
  parameter int OFS_W = 11,
  parameter int BUS_W = 36
) (
  input  logic             clk,
  input  ofsStrobe_t       strb,
  input  logic [2:0]       presetCode,
  input  logic             serBit,
  input  logic [BUS_W-1:0] busA,
  output logic [OFS_W-1:0] offX,
  output logic [OFS_W-1:0] offY
);
  localparam int CHAIN_W = 2 * OFS_W;

  logic [CHAIN_W-1:0] chainQ;
  logic [OFS_W-1:0]   presetVal;

  assign presetVal = OFS_W'(presetValue(presetCode));

  always_ff @(posedge clk) begin
    if (strb.clearAll)        chainQ <= '0;
    else if (strb.loadPreset) chainQ <= {presetVal, presetVal};
    else if (strb.shiftIn)    chainQ <= {chainQ[CHAIN_W-2:0], serBit};
    else if (strb.loadY)      chainQ[CHAIN_W-1:OFS_W] <= busA[OFS_W-1:0];
    else if (strb.loadX)      chainQ[OFS_W-1:0] <= busA[OFS_W-1:0];
  end

  assign offY = chainQ[CHAIN_W-1:OFS_W];
  assign offX = chainQ[OFS_W-1:0];

  // R4: with no strobe the chain holds its value
  a_r4_hold: assert property (@(posedge clk)
    !(|strb) |=> $stable(chainQ));

endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import offload_pkg::*;
#(
  parameter int OFS_W = 11,
  parameter int BUS_W = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selHi,
  input  logic             serEnN,
  input  logic             serData,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] busA,
  output logic [OFS_W-1:0] offX,
  output logic [OFS_W-1:0] offY,
  output logic             progDone
);
  localparam int CHAIN_LEN = 2 * OFS_W;

  ofsStrobe_t strb;
  logic [2:0] selCode;

  assign selCode = {selHi, serEnN, serData};

  ofl_ctrl #(.CHAIN_LEN(CHAIN_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .selCode  (selCode),
    .serEnN   (serEnN),
    .wrEn     (wrEn),
    .strb     (strb),
    .progDone (progDone)
  );

  ofl_data #(.OFS_W(OFS_W), .BUS_W(BUS_W)) uData (
    .clk        (clk),
    .strb       (strb),
    .presetCode (selCode),
    .serBit     (serData),
    .busA       (busA),
    .offX       (offX),
    .offY       (offY)
  );

  // R7: offsets frozen once programming is complete
  a_r7_offsets_frozen: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> ($stable(offX) && $stable(offY)));

endmodule

// File: tb/tb_offset_loader.sv
module tb_offset_loader;
  localparam int OFS_W = 11;
  localparam int BUS_W = 36;
  localparam int CH_W  = 2 * OFS_W;

  logic clk = 1'b0;
  logic rstN, selHi, serEnN, serData, wrEn;
  logic [BUS_W-1:0] busA;
  logic [OFS_W-1:0] offX, offY;
  logic progDone;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  offset_loader #(.OFS_W(OFS_W), .BUS_W(BUS_W)) dut (
    .clk(clk), .rstN(rstN), .selHi(selHi), .serEnN(serEnN), .serData(serData),
    .wrEn(wrEn), .busA(busA), .offX(offX), .offY(offY), .progDone(progDone)
  );

  function automatic int expPreset(input logic [2:0] code);
    case (code)
      3'b000: return 8;
      3'b001: return 16;
      3'b010: return 64;
      3'b011: return 256;
      3'b100: return 1024;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enterReset(input logic [2:0] code);
    @(negedge clk);
    rstN = 1'b0;
    {selHi, serEnN, serData} = code;
    wrEn = 1'b0;
    stepCycle();
    stepCycle();
  endtask

  task automatic leaveReset();
    rstN = 1'b1;
    selHi = 1'($urandom);
    serEnN = 1'b1;
    serData = 1'($urandom);
  endtask

  task automatic testPreset(input logic [2:0] code);
    int e;
    e = expPreset(code);
    enterReset(code);
    check(offX == OFS_W'(e) && offY == OFS_W'(e), "R2 preset value", {offY, offX}, {OFS_W'(e), OFS_W'(e)});
    check(progDone == 1'b1, "R2 preset done", progDone, 1);
    leaveReset();
    for (int i = 0; i < 6; i++) begin
      {selHi, serEnN, serData} = 3'($urandom);
      wrEn = 1'($urandom);
      busA = {$urandom, $urandom};
      stepCycle();
    end
    check(offX == OFS_W'(e) && offY == OFS_W'(e), "R1 pins ignored after reset", {offY, offX}, {OFS_W'(e), OFS_W'(e)});
    wrEn = 1'b0;
    serEnN = 1'b1;
  endtask

  task automatic testSerial(input logic [CH_W-1:0] word, input bit tryWrites);
    logic [CH_W-1:0] model;
    model = '0;
    enterReset(3'b101);
    check(offX == 0 && offY == 0, "R3 serial reset clear", {offY, offX}, 0);
    check(progDone == 1'b0, "R3 serial reset done low", progDone, 0);
    leaveReset();
    for (int b = CH_W - 1; b >= 0; b--) begin
      int gap;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        serEnN = 1'b1;
        serData = 1'($urandom);
        wrEn = tryWrites ? 1'($urandom) : 1'b0;
        busA = {$urandom, $urandom};
        stepCycle();
      end
      if (gap > 0)
        check({offY, offX} == model, "R4 R8 idle edges keep chain", {offY, offX}, model);
      if (b == 0)
        check(progDone == 1'b0, "R5 no early done", progDone, 0);
      serEnN = 1'b0;
      serData = word[b];
      wrEn = tryWrites ? 1'($urandom) : 1'b0;
      busA = {$urandom, $urandom};
      stepCycle();
      model = {model[CH_W-2:0], word[b]};
      check({offY, offX} == model, "R4 shift", {offY, offX}, model);
    end
    check(offY == word[CH_W-1:OFS_W] && offX == word[OFS_W-1:0], "R5 bit order", {offY, offX}, word);
    check(progDone == 1'b1, "R5 done after last bit", progDone, 1);
    for (int i = 0; i < 4; i++) begin
      serEnN = 1'b0;
      serData = 1'($urandom);
      wrEn = 1'b1;
      busA = {$urandom, $urandom};
      stepCycle();
    end
    check({offY, offX} == word && progDone, "R7 frozen after serial", {progDone, offY, offX}, {1'b1, word});
    serEnN = 1'b1;
    wrEn = 1'b0;
  endtask

  task automatic testParallel(input logic [BUS_W-1:0] w0, input logic [BUS_W-1:0] w1);
    enterReset(3'b110);
    check(offX == 0 && offY == 0 && !progDone, "R3 parallel reset", {progDone, offY, offX}, 0);
    leaveReset();
    for (int g = 0; g < 3; g++) begin
      serEnN = 1'($urandom);
      serData = 1'($urandom);
      stepCycle();
    end
    check(offX == 0 && offY == 0, "R8 serial ignored in parallel", {offY, offX}, 0);
    wrEn = 1'b1;
    busA = w0;
    stepCycle();
    wrEn = 1'b0;
    check(offY == w0[OFS_W-1:0] && offX == 0, "R6 first write loads Y", {offY, offX}, {w0[OFS_W-1:0], 11'd0});
    check(progDone == 1'b0, "R6 done low after one write", progDone, 0);
    busA = {$urandom, $urandom};
    stepCycle();
    wrEn = 1'b1;
    busA = w1;
    stepCycle();
    check(offX == w1[OFS_W-1:0] && offY == w0[OFS_W-1:0], "R6 second write loads X", {offY, offX}, {w0[OFS_W-1:0], w1[OFS_W-1:0]});
    check(progDone == 1'b1, "R6 done after second write", progDone, 1);
    busA = {$urandom, $urandom};
    serEnN = 1'b0;
    stepCycle();
    stepCycle();
    check(offX == w1[OFS_W-1:0] && offY == w0[OFS_W-1:0] && progDone, "R7 frozen after parallel",
          {progDone, offY, offX}, {1'b1, w0[OFS_W-1:0], w1[OFS_W-1:0]});
    wrEn = 1'b0;
    serEnN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; selHi = 1'b0; serEnN = 1'b1; serData = 1'b0; wrEn = 1'b0; busA = '0;
    for (int c = 0; c < 8; c++)
      if (c != 5 && c != 6) testPreset(3'(c));
    testSerial(22'h3FFFFF, 1'b0);
    testSerial(22'h200001, 1'b1);
    for (int n = 0; n < 12; n++) testSerial(22'($urandom), 1'b1);
    testParallel({25'h1FFFFFF, 11'h7FF}, {25'h1555555, 11'h000});
    for (int n = 0; n < 12; n++) testParallel({$urandom, $urandom}, {$urandom, $urandom});
    testPreset(3'b100);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule